// File: doc/BRIEF.md
# Cascadable Complex FIR Filter

This block is a direct-form finite impulse response filter for complex samples. Every accepted sample carries a real and an imaginary part. Each tap holds one complex coefficient and forms the full complex product of that coefficient with the sample delayed by the tap's index. The product is built from four real multipliers. Their outputs are combined in pairs by one subtractor, which gives the real part, and one adder, which gives the imaginary part. The real parts of all taps are summed into the real output and the imaginary parts into the imaginary output. Both sums run at full precision.

Input and output are streams qualified by a valid flag. A partial-sum input for each component is added into the result. Several instances can therefore be chained to build a longer filter: one instance's outputs feed the next instance's partial-sum inputs. Coefficients are loaded one tap at a time through a write port that carries a tap index and the two coefficient parts. The default build has two taps with 9-bit signed samples and coefficients. A one-tap build with 18-bit operands comes from the same source by changing parameters.

Top module: `cplx_fir_cascade`

## Requirements
- R1: For each tap, the real part of the product equals sample_real·coef_real − sample_imag·coef_imag. All values are two's complement.
- R2: For each tap, the imaginary part of the product equals sample_real·coef_imag + sample_imag·coef_real.
- R3: The output for accepted sample n is the exact sum over taps k of coef[k]·x[n−k], separately for the real and imaginary parts. Tap 0 multiplies the newest sample. The sum never overflows, even when samples and coefficients sit at the most negative value.
- R4: The partial-sum inputs (real and imaginary) are sampled on the same clock edge as the accepted sample and added exactly into that sample's result.
- R5: The sample history advances only on an edge where in_valid is high. Idle cycles between samples do not change any result.
- R6: out_valid equals in_valid delayed by exactly two clock edges. While out_valid is low, out_re and out_im hold their last values.
- R7: A write with coef_we high and coef_idx = k < TAPS sets tap k's coefficient. A sample accepted on the same edge as the write still uses the old value; every later sample uses the new one. A write with coef_idx ≥ TAPS changes nothing.
- R8: A synchronous active-low reset clears the sample history to zero, and clears the pipeline, out_valid, out_re and out_im. Coefficients keep their values through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accepts in_re/in_im and the partial-sum inputs this edge |
| in_re | input | DW | Sample real part, signed |
| in_im | input | DW | Sample imaginary part, signed |
| casc_re_i | input | OUT_W | Partial real sum from a previous instance, signed |
| casc_im_i | input | OUT_W | Partial imaginary sum from a previous instance, signed |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | IW | Tap index of the write |
| coef_re | input | CW | Coefficient real part, signed |
| coef_im | input | CW | Coefficient imaginary part, signed |
| out_valid | output | 1 | Result valid |
| out_re | output | OUT_W | Real result, signed |
| out_im | output | OUT_W | Imaginary result, signed |

## Verification
A corrupted sample history shows up in the very next result, two edges after the following accepted sample. It then persists for up to TAPS−1 further results, until the bad entry has shifted out. A wrong coefficient or a swapped subtract and add in a tap skews every result that uses that tap, again two edges after each sample. A broken valid pipeline shows up as out_valid misaligned against in_valid on the next edges. Results released during idle cycles show up as output changes while out_valid is low.

// File: rtl/cfir_pkg.sv
// Package cfir_pkg
// Shared width arithmetic for the complex FIR filter.
// Assumes every operand is two's complement and that the guard counts are non-negative.
package cfir_pkg;

    // Bits of one complex-tap part: full product plus one bit for the add or subtract.
    function automatic int tap_width(input int dw, input int cw);
        return dw + cw + 1;
    endfunction

    // Bits of the output: tap width, plus growth from summing the taps, plus cascade headroom.
    function automatic int out_width(input int dw, input int cw, input int taps, input int casc_guard);
        return tap_width(dw, cw) + $clog2(taps) + casc_guard;
    endfunction

endpackage

// File: rtl/cfir_coef_bank.sv
// Module cfir_coef_bank
// Holds one complex coefficient per tap and updates the addressed tap on a write.
// Assumes indices at or above TAPS are to be ignored. The registers have no reset,
// so the values survive the filter's reset.
module cfir_coef_bank #(
    parameter int TAPS = 2,
    parameter int CW   = 9,
    parameter int IW   = 2
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic signed [CW-1:0] wr_re,
    input  logic signed [CW-1:0] wr_im,
    output logic signed [CW-1:0] h_re [TAPS],
    output logic signed [CW-1:0] h_im [TAPS]
);

    // Write the addressed coefficient; an index out of range matches no tap.
    always_ff @(posedge clk) begin
        for (int k = 0; k < TAPS; k++) begin
            if (wr_en && (wr_idx == IW'(k))) begin
                h_re[k] <= wr_re;
                h_im[k] <= wr_im;
            end
        end
    end

endmodule

// File: rtl/cfir_delay_line.sv
// Module cfir_delay_line
// Builds the sample window for the taps. Element 0 is the incoming sample;
// element k is the sample accepted k accepts earlier.
// Assumes the window moves only on accepted samples. Reset fills the history with zeros.
module cfir_delay_line #(
    parameter int TAPS = 2,
    parameter int DW   = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic signed [DW-1:0] win_re [TAPS],
    output logic signed [DW-1:0] win_im [TAPS]
);

    // Newest position of the window is the live input.
    assign win_re[0] = in_re;
    assign win_im[0] = in_im;

    generate
        if (TAPS > 1) begin : g_hist
            localparam int DEPTH = TAPS - 1;
            logic signed [DW-1:0] hist_re [DEPTH];
            logic signed [DW-1:0] hist_im [DEPTH];

            // Shift the history by one place on every accepted sample.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int k = 0; k < DEPTH; k++) begin
                        hist_re[k] <= '0;
                        hist_im[k] <= '0;
                    end
                end else if (adv) begin
                    hist_re[0] <= in_re;
                    hist_im[0] <= in_im;
                    for (int k = 1; k < DEPTH; k++) begin
                        hist_re[k] <= hist_re[k-1];
                        hist_im[k] <= hist_im[k-1];
                    end
                end
            end

            for (genvar k = 1; k < TAPS; k++) begin : g_win
                assign win_re[k] = hist_re[k-1];
                assign win_im[k] = hist_im[k-1];
            end
        end
    endgenerate

endmodule

// File: rtl/cfir_cmac_tap.sv
// Module cfir_cmac_tap
// One complex tap: four real multipliers, registered, then one subtractor for the
// real part and one adder for the imaginary part.
// Assumes the caller enables the register only on accepted samples.
module cfir_cmac_tap #(
    parameter int DW = 9,
    parameter int CW = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic signed [DW-1:0]   x_re,
    input  logic signed [DW-1:0]   x_im,
    input  logic signed [CW-1:0]   h_re,
    input  logic signed [CW-1:0]   h_im,
    output logic signed [DW+CW:0]  prod_re,
    output logic signed [DW+CW:0]  prod_im
);

    localparam int PW = DW + CW;

    logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [PW-1:0] q_rr, q_ii, q_ri, q_ir;

    // Form the four cross products of the complex multiply.
    always_comb begin
        m_rr = PW'(x_re) * PW'(h_re);
        m_ii = PW'(x_im) * PW'(h_im);
        m_ri = PW'(x_re) * PW'(h_im);
        m_ir = PW'(x_im) * PW'(h_re);
    end

    // Register the products for accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_rr <= '0;
            q_ii <= '0;
            q_ri <= '0;
            q_ir <= '0;
        end else if (en) begin
            q_rr <= m_rr;
            q_ii <= m_ii;
            q_ri <= m_ri;
            q_ir <= m_ir;
        end
    end

    // Pair the registered products: subtract on the real path, add on the imaginary path.
    always_comb begin
        prod_re = {q_rr[PW-1], q_rr} - {q_ii[PW-1], q_ii};
        prod_im = {q_ri[PW-1], q_ri} + {q_ir[PW-1], q_ir};
    end

endmodule

// File: rtl/cfir_sum_stage.sv
// Module cfir_sum_stage
// Adds all tap results and the partial-sum inputs, and registers the complex output.
// Assumes OUT_W is wider than TW, so every tap result is sign-extended without loss.
module cfir_sum_stage #(
    parameter int TAPS  = 2,
    parameter int TW    = 19,
    parameter int OUT_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [TW-1:0]    tap_re [TAPS],
    input  logic signed [TW-1:0]    tap_im [TAPS],
    input  logic signed [OUT_W-1:0] casc_re,
    input  logic signed [OUT_W-1:0] casc_im,
    output logic signed [OUT_W-1:0] sum_re,
    output logic signed [OUT_W-1:0] sum_im
);

    localparam int EXT = OUT_W - TW;

    logic signed [OUT_W-1:0] acc_re, acc_im;

    // Sum the sign-extended tap parts, starting from the partial-sum inputs.
    always_comb begin
        acc_re = casc_re;
        acc_im = casc_im;
        for (int k = 0; k < TAPS; k++) begin
            acc_re = acc_re + {{EXT{tap_re[k][TW-1]}}, tap_re[k]};
            acc_im = acc_im + {{EXT{tap_im[k][TW-1]}}, tap_im[k]};
        end
    end

    // Load the output only for valid pipeline slots; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_re <= '0;
            sum_im <= '0;
        end else if (en) begin
            sum_re <= acc_re;
            sum_im <= acc_im;
        end
    end

endmodule

// File: rtl/cplx_fir_cascade.sv
// Module cplx_fir_cascade
// Complex direct-form FIR filter with partial-sum inputs for chaining.
// There are two register stages: the tap products with the partial sums, then the output.
// Assumes CASC_GUARD >= 1 and that the chain depth stays within 2**CASC_GUARD instances.
module cplx_fir_cascade #(
    parameter int TAPS       = 2,
    parameter int DW         = 9,
    parameter int CW         = 9,
    parameter int CASC_GUARD = 3,
    localparam int IW        = $clog2(TAPS + 1),
    localparam int TW        = cfir_pkg::tap_width(DW, CW),
    localparam int OUT_W     = cfir_pkg::out_width(DW, CW, TAPS, CASC_GUARD)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [DW-1:0]    in_re,
    input  logic signed [DW-1:0]    in_im,
    input  logic signed [OUT_W-1:0] casc_re_i,
    input  logic signed [OUT_W-1:0] casc_im_i,
    input  logic                    coef_we,
    input  logic [IW-1:0]           coef_idx,
    input  logic signed [CW-1:0]    coef_re,
    input  logic signed [CW-1:0]    coef_im,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_re,
    output logic signed [OUT_W-1:0] out_im
);

    logic signed [CW-1:0]    h_re   [TAPS];
    logic signed [CW-1:0]    h_im   [TAPS];
    logic signed [DW-1:0]    win_re [TAPS];
    logic signed [DW-1:0]    win_im [TAPS];
    logic signed [TW-1:0]    tap_re [TAPS];
    logic signed [TW-1:0]    tap_im [TAPS];
    logic signed [OUT_W-1:0] casc_re_q, casc_im_q;
    logic                    vld_s1;
    logic signed [DW-1:0]    dl0_re, dl0_im;

    cfir_coef_bank #(.TAPS(TAPS), .CW(CW), .IW(IW)) u_coef (
        .clk    (clk),
        .wr_en  (coef_we),
        .wr_idx (coef_idx),
        .wr_re  (coef_re),
        .wr_im  (coef_im),
        .h_re   (h_re),
        .h_im   (h_im)
    );

    cfir_delay_line #(.TAPS(TAPS), .DW(DW)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (in_valid),
        .in_re  (in_re),
        .in_im  (in_im),
        .win_re (win_re),
        .win_im (win_im)
    );

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            cfir_cmac_tap #(.DW(DW), .CW(CW)) u_tap (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (in_valid),
                .x_re    (win_re[k]),
                .x_im    (win_im[k]),
                .h_re    (h_re[k]),
                .h_im    (h_im[k]),
                .prod_re (tap_re[k]),
                .prod_im (tap_im[k])
            );
        end
        // Newest stored history entry, brought out for the bound checker.
        if (TAPS > 1) begin : g_dl0
            assign dl0_re = win_re[1];
            assign dl0_im = win_im[1];
        end else begin : g_nodl
            assign dl0_re = in_re;
            assign dl0_im = in_im;
        end
    endgenerate

    // Stage one: capture the partial sums and the valid flag beside the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_s1    <= 1'b0;
            casc_re_q <= '0;
            casc_im_q <= '0;
        end else begin
            vld_s1 <= in_valid;
            if (in_valid) begin
                casc_re_q <= casc_re_i;
                casc_im_q <= casc_im_i;
            end
        end
    end

    cfir_sum_stage #(.TAPS(TAPS), .TW(TW), .OUT_W(OUT_W)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (vld_s1),
        .tap_re  (tap_re),
        .tap_im  (tap_im),
        .casc_re (casc_re_q),
        .casc_im (casc_im_q),
        .sum_re  (out_re),
        .sum_im  (out_im)
    );

    // Stage two: the valid flag follows the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= vld_s1;
    end

endmodule

// File: rtl/cfir_checks.sv
// Module cfir_checks
// Assertion checker for cplx_fir_cascade, attached by the bind below.
// Assumes the reset is held for at least one clock edge before use.
module cfir_checks #(
    parameter int DW     = 9,
    parameter int OUT_W  = 23,
    parameter bit HAS_DL = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic signed [DW-1:0]    in_re,
    input logic signed [DW-1:0]    in_im,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_re,
    input logic signed [OUT_W-1:0] out_im,
    input logic signed [DW-1:0]    dl0_re,
    input logic signed [DW-1:0]    dl0_im
);

    logic [1:0] live;

    // Count edges since reset, saturating, so that history checks see only post-reset cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          live <= 2'd0;
        else if (live != 2'd3) live <= live + 2'd1;
    end

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live >= 2'd1 && !out_valid) |-> ($stable(out_re) && $stable(out_im)));

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_re == '0 && out_im == '0));

    generate
        if (HAS_DL) begin : g_dl
            assert_shift_on_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (live >= 2'd1 && $past(in_valid)) |->
                (dl0_re == $past(in_re) && dl0_im == $past(in_im)));

            assert_hold_on_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (live >= 2'd1 && !$past(in_valid)) |->
                ($stable(dl0_re) && $stable(dl0_im)));
        end
    endgenerate

endmodule

bind cplx_fir_cascade cfir_checks #(
    .DW     (DW),
    .OUT_W  (OUT_W),
    .HAS_DL (TAPS > 1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_re     (in_re),
    .in_im     (in_im),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im),
    .dl0_re    (dl0_re),
    .dl0_im    (dl0_im)
);

// File: tb/sim_cplx_fir_cascade.sv
module sim_cplx_fir_cascade;

    localparam int CLK_PERIOD = 10;
    localparam int TAPS  = 2;
    localparam int DW    = 9;
    localparam int CW    = 9;
    localparam int OUT_W = 23;
    localparam int IW    = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [DW-1:0]    in_re = '0, in_im = '0;
    logic signed [OUT_W-1:0] casc_re_i = '0, casc_im_i = '0;
    logic                    coef_we = 1'b0;
    logic [IW-1:0]           coef_idx = '0;
    logic signed [CW-1:0]    coef_re = '0, coef_im = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_re, out_im;

    cplx_fir_cascade #(.TAPS(TAPS), .DW(DW), .CW(CW)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    bit chk_en   = 1'b0;

    // Bench model state.
    longint mx_re [TAPS];
    longint mx_im [TAPS];
    longint mh_re [TAPS];
    longint mh_im [TAPS];
    bit     sv [2];
    longint se_re [2];
    longint se_im [2];
    longint last_re = 0, last_im = 0;

    function automatic int rnd_s(input int bits);
        return int'($urandom_range(0, (1 << bits) - 1)) - (1 << (bits - 1));
    endfunction

    task automatic check_eq(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        if (sv[1]) begin
            last_re = se_re[1];
            last_im = se_im[1];
        end
        check_eq("R6", "out_valid", longint'(out_valid), longint'(sv[1]));
        check_eq(tag, "out_re", longint'(out_re), last_re);
        check_eq(tag, "out_im", longint'(out_im), last_im);
    endtask

    // One clock: check outputs, update the model, drive the next inputs.
    task automatic step(input bit vld, input int xr, input int xi, input longint cr, input longint ci,
                        input bit we, input int idx, input int hr, input int hi, input string tag);
        longint ar, ai;
        @(negedge clk);
        if (chk_en) check_outputs(tag);
        sv[1] = sv[0]; se_re[1] = se_re[0]; se_im[1] = se_im[0];
        sv[0] = vld;
        if (vld) begin
            for (int k = TAPS - 1; k > 0; k--) begin
                mx_re[k] = mx_re[k-1];
                mx_im[k] = mx_im[k-1];
            end
            mx_re[0] = xr; mx_im[0] = xi;
            ar = cr; ai = ci;
            for (int k = 0; k < TAPS; k++) begin
                ar += mx_re[k] * mh_re[k] - mx_im[k] * mh_im[k];
                ai += mx_re[k] * mh_im[k] + mx_im[k] * mh_re[k];
            end
            se_re[0] = ar; se_im[0] = ai;
        end
        if (we && idx < TAPS) begin
            mh_re[idx] = hr;
            mh_im[idx] = hi;
        end
        in_valid  = vld;
        in_re     = DW'(xr);
        in_im     = DW'(xi);
        casc_re_i = OUT_W'(cr);
        casc_im_i = OUT_W'(ci);
        coef_we   = we;
        coef_idx  = IW'(idx);
        coef_re   = CW'(hr);
        coef_im   = CW'(hi);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; chk_en = 1'b0;
        in_valid = 1'b0; coef_we = 1'b0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < TAPS; k++) begin
            mx_re[k] = 0; mx_im[k] = 0;
        end
        sv[0] = 0; sv[1] = 0; last_re = 0; last_im = 0;
        rst_n = 1'b1; chk_en = 1'b1;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr_coef(input int idx, input int hr, input int hi, input string tag);
        step(0, 0, 0, 0, 0, 1, idx, hr, hi, tag);
    endtask

    task automatic sample(input int xr, input int xi, input string tag);
        step(1, xr, xi, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        void'($urandom(32'd20250601));
        for (int k = 0; k < TAPS; k++) begin
            mh_re[k] = 0; mh_im[k] = 0;
        end
        do_reset();
        // R8: outputs clear after reset.
        idle(2, "R8");

        // R1: real coefficient on tap 0 only; real path subtracts.
        wr_coef(0, 3, 0, "R1");
        wr_coef(1, 0, 0, "R1");
        sample(5, -7, "R1");
        for (int i = 0; i < 10; i++) sample(rnd_s(DW), rnd_s(DW), "R1");
        wr_coef(0, 0, 4, "R1");
        for (int i = 0; i < 10; i++) sample(rnd_s(DW), rnd_s(DW), "R1");

        // R2: imaginary path adds both cross products.
        wr_coef(0, rnd_s(CW), rnd_s(CW), "R2");
        for (int i = 0; i < 12; i++) sample(rnd_s(DW), rnd_s(DW), "R2");
        idle(2, "R2");

        // R3: both taps live, random and most-negative corners.
        wr_coef(0, -256, -256, "R3");
        wr_coef(1, -256, 255, "R3");
        sample(-256, -256, "R3");
        sample(-256, -256, "R3");
        sample(-256, 255, "R3");
        sample(255, -256, "R3");
        for (int r = 0; r < 6; r++) begin
            wr_coef(0, rnd_s(CW), rnd_s(CW), "R3");
            wr_coef(1, rnd_s(CW), rnd_s(CW), "R3");
            for (int i = 0; i < 15; i++) sample(rnd_s(DW), rnd_s(DW), "R3");
        end
        idle(2, "R3");

        // R4: partial-sum inputs added on the accepting edge.
        for (int i = 0; i < 30; i++)
            step(1, rnd_s(DW), rnd_s(DW), longint'(rnd_s(22)), longint'(rnd_s(22)), 0, 0, 0, 0, "R4");
        step(1, -256, -256, -(64'sd1 << 21), (64'sd1 << 21) - 1, 0, 0, 0, 0, "R4");
        idle(2, "R4");

        // R5 / R6: random gaps between samples; data in gaps must not advance the history.
        for (int i = 0; i < 80; i++) begin
            if ($urandom_range(0, 2) == 0) step(0, rnd_s(DW), rnd_s(DW), 12345, -999, 0, 0, 0, 0, "R5");
            else sample(rnd_s(DW), rnd_s(DW), "R5");
        end
        idle(3, "R6");

        // R7: a write on the same edge as a sample applies to later samples only; idx >= TAPS ignored.
        for (int i = 0; i < 20; i++) begin
            step(1, rnd_s(DW), rnd_s(DW), 0, 0, 1, int'($urandom_range(0, 3)), rnd_s(CW), rnd_s(CW), "R7");
            sample(rnd_s(DW), rnd_s(DW), "R7");
        end
        wr_coef(2, 100, 100, "R7");
        wr_coef(3, -100, 7, "R7");
        for (int i = 0; i < 6; i++) sample(rnd_s(DW), rnd_s(DW), "R7");
        idle(2, "R7");

        // R8: mid-stream reset clears history, coefficients survive.
        for (int i = 0; i < 4; i++) sample(rnd_s(DW), rnd_s(DW), "R8");
        do_reset();
        sample(17, -9, "R8");
        sample(-3, 44, "R8");
        idle(3, "R8");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R6 watchdog: actual still running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule